// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Array Model

This block sits between a simple requester and a small conventional DRAM whose row and column indices share one narrow address bus. The requester presents a full cell address, a read or write flag and write data. The controller turns each request into a short strobe sequence. A row strobe carries the row index and copies that row of the array into an internal row buffer. A column strobe carries the column index and moves one byte between that buffer and the data path. A precharge strobe writes the buffer back into the array and closes the row.

The controller follows an open-page policy. After an access, the row stays open in the buffer. A later request to the same row issues only the column strobe. A request to a different row first closes the open row, then opens the new one. A timer forces a refresh burst at a fixed interval. The burst closes any open row and then walks every row in ascending order, opening and closing each one. The behavioural array model included here loses the contents of any row that is not restored within a retention window. A design whose refresh works therefore keeps its data over any idle time.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, req_ready is 1, all strobes are 0, rsp_done is 0, and no row is open.
- R2: On a request with no row open, the first cycle after acceptance drives dram_ras with the row (req_addr[3:2]) on dram_addr. The second cycle drives dram_cas with the column (req_addr[1:0]) on dram_addr and dram_we equal to the write flag. The third cycle raises rsp_done.
- R3: On a request to the row that is already open, no row strobe is issued. dram_cas appears in the first cycle after acceptance and rsp_done in the second.
- R4: On a request to a row other than the open one, the first cycle after acceptance drives dram_pre with the old row on dram_addr. Then follow the row strobe, the column strobe and rsp_done, as in R2.
- R5: A write changes only the addressed byte. A later read of that address returns the written byte, including after its row has been closed and reopened. Cells never written read as 0x00.
- R6: rsp_done is high for exactly one cycle per accepted request. For a read, rsp_rdata holds the addressed byte while rsp_done is high.
- R7: A request is taken only in a cycle where req_ready is 1. req_ready is 0 from acceptance until the cycle after rsp_done. A request raised and dropped while req_ready is 0 has no effect on memory contents.
- R8: Every REFRESH_CYCLES clocks a refresh becomes pending. From idle, a pending refresh first precharges the open row, if any. It then issues, for rows 0,1,2,3 in turn, a row strobe followed by a precharge of that row, with the row on dram_addr. Afterwards no row is open, so the next access follows R2.
- R9: A pending refresh takes priority over a waiting request. req_ready stays 0 from the moment a refresh is pending until its burst ends.
- R10: Stored data survives idle stretches several times longer than the array's retention window (RETAIN_CYCLES).
- R11: In each cycle at most one of dram_ras, dram_cas and dram_pre is high, and dram_we is high only together with dram_cas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Cell address: [3:2] row, [1:0] column |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle with no refresh pending; the request is taken at this edge |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid while rsp_done is high |
| dram_ras | output | 1 | Row strobe |
| dram_cas | output | 1 | Column strobe |
| dram_pre | output | 1 | Precharge / write-back strobe |
| dram_we | output | 1 | Column strobe direction, 1 = write |
| dram_addr | output | 2 | Shared bus: row index or column index, depending on the strobe |

## Verification
The assertions rely on the configured refresh interval being well inside the array's retention window. They also rely on the requester never counting on acceptance while req_ready is low. The decay and row-state checks hold only under these conditions. The stimulus keeps the request fields steady from the moment req_valid rises until acceptance. Its only exception is a deliberate write raised and withdrawn entirely within the busy cycles of an ongoing access. The bench runs with the default parameters, whose interval/retention ratio leaves a wide margin even when a refresh waits behind a row-miss access.

// File: rtl/dpc_pkg.sv
`timescale 1ns/1ps
package dpc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLOSE,
      ST_OPEN,
      ST_COL,
      ST_DONE,
      ST_RCLOSE,
      ST_RRAS,
      ST_RPRE
   } ctl_state_e;

   typedef struct packed {
      logic ras;
      logic cas;
      logic pre;
      logic we;
   } dram_cmd_t;

endpackage

// File: rtl/dpc_refresh_timer.sv
`timescale 1ns/1ps
module dpc_refresh_timer #(
   parameter int unsigned PERIOD = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);

   generate
      if (PERIOD == 1) begin : g_bad_period
         $error("refresh period must be 0 (off) or at least 2");
      end

      if (PERIOD > 1) begin : g_on
         localparam int CW = $clog2(PERIOD);
         logic [CW-1:0] cnt;
         logic          fire;

         assign fire = (cnt == CW'(PERIOD - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt     <= '0;
               pending <= 1'b0;
            end else begin
               cnt <= fire ? '0 : cnt + 1'b1;
               if (fire)
                  pending <= 1'b1;
               else if (ack)
                  pending <= 1'b0;
            end
         end

         // R8: an acknowledge only ever closes a refresh that was pending
         assert_ack_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ack |-> pending);
      end else begin : g_off
         logic unused_ack;
         assign unused_ack = ack;
         assign pending    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dpc_dram_array.sv
`timescale 1ns/1ps
module dpc_dram_array
   import dpc_pkg::*;
#(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned COLS   = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned RETAIN = 400
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  dram_cmd_t                              cmd,
   input  logic [$clog2(ROWS > COLS ? ROWS : COLS)-1:0] addr,
   input  logic [DATA_W-1:0]                      wdata,
   output logic [DATA_W-1:0]                      rdata
);

   localparam int RAW   = $clog2(ROWS);
   localparam int CAW   = $clog2(COLS);
   localparam int ROW_W = COLS * DATA_W;
   localparam int AGW   = $clog2(RETAIN + 1);
   localparam int LIM   = RETAIN - 1;

   logic [ROW_W-1:0]  mem [ROWS];
   logic [AGW-1:0]    age [ROWS];
   logic [ROW_W-1:0]  rowbuf;
   logic [RAW-1:0]    open_row;
   logic              open_v;
   logic [DATA_W-1:0] rdq;
   logic [RAW-1:0]    ra;
   logic [CAW-1:0]    ca;

   assign ra    = addr[RAW-1:0];
   assign ca    = addr[CAW-1:0];
   assign rdata = rdq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            mem[r] <= '0;
            age[r] <= '0;
         end
         rowbuf   <= '0;
         open_row <= '0;
         open_v   <= 1'b0;
         rdq      <= '0;
      end else begin
         for (int r = 0; r < ROWS; r++) begin
            if (cmd.pre && open_v && open_row == RAW'(r)) begin
               mem[r] <= rowbuf;
               age[r] <= '0;
            end else if (cmd.ras && ra == RAW'(r)) begin
               age[r] <= '0;
            end else if (age[r] == AGW'(LIM)) begin
               mem[r] <= '0;
            end else begin
               age[r] <= age[r] + 1'b1;
            end
         end
         if (cmd.ras) begin
            rowbuf   <= mem[ra];
            open_row <= ra;
            open_v   <= 1'b1;
         end
         if (cmd.pre)
            open_v <= 1'b0;
         if (cmd.cas) begin
            if (cmd.we)
               rowbuf[int'(ca)*DATA_W +: DATA_W] <= wdata;
            else
               rdq <= rowbuf[int'(ca)*DATA_W +: DATA_W];
         end
      end
   end

   // R2: a column strobe only lands on a row that the row strobe has opened
   assert_col_needs_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.cas |-> open_v);

   // R4: a new row is opened only after the previous one has been written back
   assert_open_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.ras |-> !open_v);

   generate
      for (genvar gr = 0; gr < ROWS; gr++) begin : g_retain
         // R10: no row ever reaches the end of its retention window
         assert_no_decay_R10: assert property (@(posedge clk) disable iff (!rst_n)
            age[gr] != AGW'(LIM));
      end
   endgenerate

endmodule

// File: rtl/dpc_ctrl.sv
`timescale 1ns/1ps
module dpc_ctrl
   import dpc_pkg::*;
#(
   parameter int unsigned ROWS   = 4,
   parameter int unsigned COLS   = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   input  logic                            req_write,
   input  logic [$clog2(ROWS)+$clog2(COLS)-1:0] req_addr,
   input  logic [DATA_W-1:0]               req_wdata,
   input  logic                            ref_pend,
   output logic                            ready,
   output logic                            ref_ack,
   output dram_cmd_t                       cmd,
   output logic [$clog2(ROWS > COLS ? ROWS : COLS)-1:0] dram_addr,
   output logic [DATA_W-1:0]               dram_wdata,
   output logic                            done
);

   localparam int RAW = $clog2(ROWS);
   localparam int CAW = $clog2(COLS);
   localparam int AW  = (RAW > CAW) ? RAW : CAW;

   ctl_state_e       state;
   logic [RAW-1:0]   row_q;
   logic [CAW-1:0]   col_q;
   logic             wr_q;
   logic [DATA_W-1:0] wd_q;
   logic             open_v;
   logic [RAW-1:0]   open_row;
   logic [RAW-1:0]   rcnt;
   logic [RAW-1:0]   in_row;
   logic             last_row;

   assign in_row   = req_addr[RAW+CAW-1:CAW];
   assign last_row = (rcnt == RAW'(ROWS - 1));
   assign ready    = (state == ST_IDLE) && !ref_pend;
   assign ref_ack  = (state == ST_RPRE) && last_row;
   assign done     = (state == ST_DONE);
   assign dram_wdata = wd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         row_q    <= '0;
         col_q    <= '0;
         wr_q     <= 1'b0;
         wd_q     <= '0;
         open_v   <= 1'b0;
         open_row <= '0;
         rcnt     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (ref_pend) begin
                  rcnt  <= '0;
                  state <= open_v ? ST_RCLOSE : ST_RRAS;
               end else if (req_valid) begin
                  row_q <= in_row;
                  col_q <= req_addr[CAW-1:0];
                  wr_q  <= req_write;
                  wd_q  <= req_wdata;
                  if (open_v && open_row == in_row)
                     state <= ST_COL;
                  else if (open_v)
                     state <= ST_CLOSE;
                  else
                     state <= ST_OPEN;
               end
            end
            ST_CLOSE: begin
               open_v <= 1'b0;
               state  <= ST_OPEN;
            end
            ST_OPEN: begin
               open_v   <= 1'b1;
               open_row <= row_q;
               state    <= ST_COL;
            end
            ST_COL:  state <= ST_DONE;
            ST_DONE: state <= ST_IDLE;
            ST_RCLOSE: begin
               open_v <= 1'b0;
               state  <= ST_RRAS;
            end
            ST_RRAS: state <= ST_RPRE;
            ST_RPRE: begin
               if (last_row) begin
                  state <= ST_IDLE;
               end else begin
                  rcnt  <= rcnt + 1'b1;
                  state <= ST_RRAS;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd       = '0;
      dram_addr = '0;
      unique case (state)
         ST_CLOSE, ST_RCLOSE: begin
            cmd.pre   = 1'b1;
            dram_addr = AW'(open_row);
         end
         ST_OPEN: begin
            cmd.ras   = 1'b1;
            dram_addr = AW'(row_q);
         end
         ST_COL: begin
            cmd.cas   = 1'b1;
            cmd.we    = wr_q;
            dram_addr = AW'(col_q);
         end
         ST_RRAS: begin
            cmd.ras   = 1'b1;
            dram_addr = AW'(rcnt);
         end
         ST_RPRE: begin
            cmd.pre   = 1'b1;
            dram_addr = AW'(rcnt);
         end
         default: ;
      endcase
   end

   // R11: strobes never overlap
   assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd.ras, cmd.cas, cmd.pre}));
   // R11: the direction pin is meaningful only with a column strobe
   assert_we_with_cas_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.we |-> cmd.cas);
   // R6: completion is a single-cycle pulse
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: while the requester is offered a slot, the bus is quiet
   assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !(cmd.ras || cmd.cas || cmd.pre || done));
   // R9: a pending refresh blocks new requests
   assert_refresh_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pend |-> !ready);

endmodule

// File: rtl/dram_page_ctrl.sv
`timescale 1ns/1ps
module dram_page_ctrl
   import dpc_pkg::*;
#(
   parameter int unsigned ROWS           = 4,
   parameter int unsigned COLS           = 4,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned REFRESH_CYCLES = 200,
   parameter int unsigned RETAIN_CYCLES  = 400
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [$clog2(ROWS)+$clog2(COLS)-1:0] req_addr,
   input  logic [DATA_W-1:0]       req_wdata,
   output logic                    req_ready,
   output logic                    rsp_done,
   output logic [DATA_W-1:0]       rsp_rdata,
   output logic                    dram_ras,
   output logic                    dram_cas,
   output logic                    dram_pre,
   output logic                    dram_we,
   output logic [$clog2(ROWS > COLS ? ROWS : COLS)-1:0] dram_addr
);

   localparam int RAW = $clog2(ROWS);
   localparam int CAW = $clog2(COLS);
   localparam int AW  = (RAW > CAW) ? RAW : CAW;
   localparam int BURST_MAX = 2 * ROWS + 8;

   generate
      if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
         $error("ROWS must be a power of two, at least 2");
      end
      if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
         $error("COLS must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (REFRESH_CYCLES != 0 && RETAIN_CYCLES <= REFRESH_CYCLES + BURST_MAX) begin : g_bad_refresh
         $error("refresh interval leaves no margin inside the retention window");
      end
      if (RETAIN_CYCLES < 2) begin : g_bad_retain
         $error("RETAIN_CYCLES must be at least 2");
      end
   endgenerate

   dram_cmd_t          cmd;
   logic               ref_pend;
   logic               ref_ack;
   logic [DATA_W-1:0]  bus_wdata;

   dpc_refresh_timer #(.PERIOD(REFRESH_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack     (ref_ack),
      .pending (ref_pend)
   );

   dpc_ctrl #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .ref_pend   (ref_pend),
      .ready      (req_ready),
      .ref_ack    (ref_ack),
      .cmd        (cmd),
      .dram_addr  (dram_addr),
      .dram_wdata (bus_wdata),
      .done       (rsp_done)
   );

   dpc_dram_array #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .RETAIN(RETAIN_CYCLES)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .addr  (dram_addr),
      .wdata (bus_wdata),
      .rdata (rsp_rdata)
   );

   assign dram_ras = cmd.ras;
   assign dram_cas = cmd.cas;
   assign dram_pre = cmd.pre;
   assign dram_we  = cmd.we;

   // R8: an opened row is followed directly by its column strobe or its precharge
   assert_row_then_use_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dram_ras |=> (dram_cas || dram_pre));
   // R2: completion comes right after the column strobe
   assert_done_after_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dram_cas |=> rsp_done);

endmodule

// File: tb/sim_dram_page_ctrl.sv
`timescale 1ns/1ps
module sim_dram_page_ctrl;

   localparam int REF = 200;
   localparam int RET = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_ready, rsp_done, dram_ras, dram_cas, dram_pre, dram_we;
   logic [7:0] rsp_rdata;
   logic [1:0] dram_addr;

   always #2.5 clk = ~clk;

   dram_page_ctrl #(.ROWS(4), .COLS(4), .DATA_W(8),
                    .REFRESH_CYCLES(REF), .RETAIN_CYCLES(RET)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .dram_ras(dram_ras),
      .dram_cas(dram_cas), .dram_pre(dram_pre), .dram_we(dram_we),
      .dram_addr(dram_addr)
   );

   typedef struct {
      bit ras; bit cas; bit pre; bit we;
      int addr; bit done; bit chk; logic [7:0] rd;
   } rec_t;

   rec_t       q[$];
   int         tmr;
   bit         pend;
   int         open_row;
   logic [7:0] mem [16];
   int         n_cmp = 0;
   int         n_bad = 0;
   string      tag = "R1";
   bit         finished = 0;

   function automatic void check(bit ok, string t, string what, int act, int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", t, what, act, exp, $time);
      end
   endfunction

   function automatic void push(bit ras, bit cas, bit pre, bit we, int a, bit dn, bit ck, logic [7:0] rd);
      rec_t r;
      r.ras = ras; r.cas = cas; r.pre = pre; r.we = we;
      r.addr = a; r.done = dn; r.chk = ck; r.rd = rd;
      q.push_back(r);
   endfunction

   // reference timeline, advanced once per rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         tmr = 0;
         pend = 0;
         open_row = -1;
         for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      end else begin
         bit fire;
         fire = (tmr == REF - 1);
         tmr  = fire ? 0 : tmr + 1;
         if (q.size() > 0) begin
            void'(q.pop_front());
         end else if (pend) begin
            if (open_row >= 0) push(0, 0, 1, 0, open_row, 0, 0, 8'h00);
            for (int r = 0; r < 4; r++) begin
               push(1, 0, 0, 0, r, 0, 0, 8'h00);
               push(0, 0, 1, 0, r, 0, 0, 8'h00);
            end
            open_row = -1;
            pend = 0;
         end else if (req_valid) begin
            int row, col, a;
            a   = int'(req_addr);
            row = a / 4;
            col = a % 4;
            if (open_row != row) begin
               if (open_row >= 0) push(0, 0, 1, 0, open_row, 0, 0, 8'h00);
               push(1, 0, 0, 0, row, 0, 0, 8'h00);
            end
            push(0, 1, 0, req_write, col, 0, 0, 8'h00);
            push(0, 0, 0, 0, 0, 1, !req_write, mem[a]);
            if (req_write) mem[a] = req_wdata;
            open_row = row;
         end
         if (fire) pend = 1;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         rec_t e;
         int act, exp;
         if (q.size() > 0) e = q[0];
         else begin
            e.ras = 0; e.cas = 0; e.pre = 0; e.we = 0;
            e.addr = 0; e.done = 0; e.chk = 0; e.rd = 8'h00;
         end
         act = {dram_ras, dram_cas, dram_pre, dram_we, dram_addr, rsp_done, req_ready};
         exp = {e.ras, e.cas, e.pre, e.we, 2'(e.addr), e.done, (q.size() == 0) && !pend};
         check(act == exp, tag, "pins{ras,cas,pre,we,addr,done,ready}", act, exp);
         if (e.done && e.chk)
            check(rsp_rdata == e.rd, tag, "read data (R6)", int'(rsp_rdata), int'(e.rd));
         check($onehot0({dram_ras, dram_cas, dram_pre}) && (!dram_we || dram_cas),
               "R11", "strobe exclusivity", {dram_ras, dram_cas, dram_pre, dram_we}, 0);
      end
   end

   task automatic access(input bit wr, input logic [3:0] a, input logic [7:0] d,
                         input bit poke, input logic [3:0] pa, input logic [7:0] pd,
                         output int nras, output int npre);
      nras = 0;
      npre = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = poke; req_write = 1'b1; req_addr = pa; req_wdata = pd;
      while (!rsp_done) begin
         nras += int'(dram_ras);
         npre += int'(dram_pre);
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   task automatic rd_expect(input logic [3:0] a, input logic [7:0] exp, input string t,
                            output int nras, output int npre);
      access(1'b0, a, 8'h00, 1'b0, 4'h0, 8'h00, nras, npre);
      check(rsp_rdata == exp, t, "read byte", int'(rsp_rdata), int'(exp));
      @(negedge clk);
      check(rsp_done == 1'b0, "R6", "done width", int'(rsp_done), 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #500us;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      int nr, np;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle after reset
      check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
      check({dram_ras, dram_cas, dram_pre, rsp_done} == 4'b0, "R1", "quiet after reset",
            {dram_ras, dram_cas, dram_pre, rsp_done}, 0);

      tag = "R2";
      access(1'b1, 4'd6, 8'hA5, 1'b0, 4'h0, 8'h00, nr, np);
      check(nr == 1 && np == 0, "R2", "cold access strobes", nr * 16 + np, 16);

      tag = "R3";
      access(1'b1, 4'd4, 8'h3C, 1'b0, 4'h0, 8'h00, nr, np);
      check(nr == 0 && np == 0, "R3", "page hit strobes", nr * 16 + np, 0);
      rd_expect(4'd6, 8'hA5, "R3", nr, np);
      check(nr == 0, "R3", "hit read without row strobe", nr, 0);

      tag = "R5";
      rd_expect(4'd5, 8'h00, "R5", nr, np);

      tag = "R4";
      access(1'b1, 4'd14, 8'h77, 1'b0, 4'h0, 8'h00, nr, np);
      check(nr == 1 && np == 1, "R4", "row miss strobes", nr * 16 + np, 17);
      rd_expect(4'd4, 8'h3C, "R5", nr, np);
      check(nr == 1 && np == 1, "R4", "reopen after write-back", nr * 16 + np, 17);

      tag = "R7";
      access(1'b0, 4'd4, 8'h00, 1'b1, 4'd4, 8'hFF, nr, np);
      rd_expect(4'd4, 8'h3C, "R7", nr, np);

      tag = "R8";
      repeat (230) @(negedge clk);
      rd_expect(4'd14, 8'h77, "R8", nr, np);
      check(nr == 1 && np == 0, "R8", "cold after refresh", nr * 16 + np, 16);

      tag = "R9";
      for (int k = 0; k < 90; k++) begin
         access(k[0], 4'((k * 5) % 16), 8'(k * 3 + 1), 1'b0, 4'h0, 8'h00, nr, np);
      end

      tag = "R10";
      for (int a = 0; a < 16; a++) begin
         access(1'b1, 4'(a), 8'(a * 17 + 3), 1'b0, 4'h0, 8'h00, nr, np);
      end
      repeat (3 * RET) @(negedge clk);
      for (int a = 0; a < 16; a++) begin
         rd_expect(4'(a), 8'(a * 17 + 3), "R10", nr, np);
      end

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule